// File: doc/BRIEF.md
# Addressed Packet Receiver with Length Guard

This block sits behind a byte receiver and turns a stream of bytes into one packet in a local buffer. A packet is a destination byte, a length byte, `length` payload bytes and one trailing check byte. The receiver is armed with a `start` pulse. It takes the destination byte first and keeps the packet only when that byte names this node or is the all-ones broadcast value. It then stores the length byte and refuses the packet when the length reaches the caller's ceiling. Otherwise it stores the payload and the check byte. Every stored byte leaves through a plain write port, at an address that begins at zero for each packet. The check byte is stored but not verified; a later stage does that.

Bytes arrive on a valid/ready stream. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. The producer must hold `in_data` and `in_bad` steady while `in_valid` is high and `in_ready` is low. `in_ready` is low whenever the receiver is not armed, so back-pressure lasts from the result until the next `start`. The buffer write port has no stall: the buffer takes a write in every cycle in which `wr_en` is high. The result comes as a one-cycle `done` pulse with `ok` and a two-bit cause code. Until that pulse has been given, the receiver takes no new packet.

Top module: `addr_pkt_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready`, `wr_en`, `done` and `ok` are 0 and `err_code` is 0.
- R2: `in_ready` is high only between a `start` taken in the idle state and the result. A `start` while a packet is in progress, or during the result cycle, has no effect. With no `start`, no byte is consumed. `own_addr` and `max_len` are sampled when the `start` is taken.
- R3: The first byte is kept when it equals `own_addr` or is 0xFF (all ones). A kept first byte is written at buffer address 0. Any other first byte is not written, and the packet ends with error code 1.
- R4: With parameter `ACCEPT_ALL` = 1, every first byte value is kept and written at address 0.
- R5: The second byte (the length) is always written at address 1. When it is greater than or equal to `max_len`, the packet ends with error code 2 and no further byte is consumed.
- R6: Otherwise, length+1 further bytes (the payload, then the check byte) are written in arrival order at addresses 2 to length+2. The packet then ends with `ok` = 1 and code 0.
- R7: A byte consumed while `in_bad` is high is not written, and the packet ends at once with error code 3.
- R8: `done` is high for exactly one cycle, the cycle after the final handshake, and `in_ready` is low in that cycle. `ok` and `err_code` are nonzero only while `done` is high. `ok` is 1 exactly when `err_code` is 0.
- R9: `wr_en` is high only in a handshake cycle with `in_bad` low. Within a packet, `wr_addr` starts at 0 and rises by one with each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Arms the receiver for one packet |
| own_addr | input | W | Address of this node |
| max_len | input | W | Length ceiling; a length at or above it is refused |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | W | Received byte |
| in_bad | input | 1 | Byte-level receive error flag for `in_data` |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | W+1 | Buffer write address |
| wr_data | output | W | Buffer write data |
| done | output | 1 | One-cycle result pulse |
| ok | output | 1 | Packet received completely (valid with `done`) |
| err_code | output | 2 | 0 none, 1 address mismatch, 2 oversize, 3 byte error |

## Verification
The checker compares written bytes with the live `own_addr` and `max_len` pins. It therefore assumes that both pins stay unchanged from the `start` of a packet until its `done`, and that `in_bad` is meaningful only while `in_valid` is high. The stimulus changes the node address and the ceiling only between packets, after the result has been seen. It holds each offered byte until that byte is taken, and it switches the stream only between the default instance and the accept-all instance while both are idle. The sweeps cover every destination value, lengths on both sides of several ceilings, the largest length, and a receive error at every byte position.

// File: rtl/pktrx_pkg.sv
package pktrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEST,
    ST_LEN,
    ST_BODY,
    ST_RESULT
  } rx_state_e;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_ADDR = 2'd1,
    RC_SIZE = 2'd2,
    RC_BYTE = 2'd3
  } rx_code_e;
endpackage

// File: rtl/pktrx_dest_filter.sv
module pktrx_dest_filter #(
  parameter int W          = 8,
  parameter bit ACCEPT_ALL = 1'b0
) (
  input  logic [W-1:0] dest,
  input  logic [W-1:0] own,
  output logic         hit
);
  localparam logic [W-1:0] BCAST = {W{1'b1}};

  if (ACCEPT_ALL) begin : g_all
    logic unused_ok;
    assign unused_ok = ^{dest, own};
    assign hit = 1'b1;
  end else begin : g_filt
    logic own_match;
    logic bcast_match;
    assign own_match   = (dest == own);
    assign bcast_match = (dest == BCAST);
    assign hit         = own_match | bcast_match;
  end
endmodule

// File: rtl/pktrx_len_guard.sv
module pktrx_len_guard #(
  parameter int W = 8
) (
  input  logic [W-1:0] len_byte,
  input  logic [W-1:0] ceiling,
  output logic         too_long,
  output logic [W:0]   body_count
);
  // payload bytes plus the trailing check byte
  assign too_long   = (len_byte >= ceiling);
  assign body_count = {1'b0, len_byte} + (W+1)'(1);
endmodule

// File: rtl/pktrx_counters.sv
module pktrx_counters #(
  parameter int W  = 8,
  parameter int PW = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          load,
  input  logic [W:0]    load_val,
  output logic [PW-1:0] ptr,
  output logic          last
);
  logic [W:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      remain <= '0;
    end else begin
      if (clear)
        ptr <= '0;
      else if (step)
        ptr <= ptr + PW'(1);

      if (clear)
        remain <= '0;
      else if (load)
        remain <= load_val;
      else if (step && remain != '0)
        remain <= remain - (W+1)'(1);
    end
  end

  assign last = (remain == (W+1)'(1));
endmodule

// File: rtl/addr_pkt_rx.sv
module addr_pkt_rx
  import pktrx_pkg::*;
#(
  parameter int W          = 8,
  parameter bit ACCEPT_ALL = 1'b0,
  localparam int PW        = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  own_addr,
  input  logic [W-1:0]  max_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          in_bad,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [W-1:0]  wr_data,
  output logic          done,
  output logic          ok,
  output logic [1:0]    err_code
);
  rx_state_e st, st_nx;
  rx_code_e  code_nx, code_q;
  logic [W-1:0] own_q, max_q;
  logic hs, good, hit, too_long, last, fin, ok_q, arm, load;
  logic [W:0] body_cnt;
  logic [PW-1:0] ptr;

  assign hs   = in_valid & in_ready;
  assign good = hs & ~in_bad;
  assign arm  = (st == ST_IDLE) & start;

  pktrx_dest_filter #(.W(W), .ACCEPT_ALL(ACCEPT_ALL)) u_filt (
    .dest (in_data),
    .own  (own_q),
    .hit  (hit)
  );

  pktrx_len_guard #(.W(W)) u_guard (
    .len_byte   (in_data),
    .ceiling    (max_q),
    .too_long   (too_long),
    .body_count (body_cnt)
  );

  assign load = good & (st == ST_LEN) & ~too_long;

  pktrx_counters #(.W(W), .PW(PW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (arm),
    .step     (wr_en),
    .load     (load),
    .load_val (body_cnt),
    .ptr      (ptr),
    .last     (last)
  );

  always_comb begin
    in_ready = (st == ST_DEST) || (st == ST_LEN) || (st == ST_BODY);
    wr_en    = good && ((st != ST_DEST) || hit);
  end

  always_comb begin
    st_nx   = st;
    fin     = 1'b0;
    code_nx = RC_NONE;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_DEST;
      ST_DEST: if (hs) begin
        if (in_bad) begin
          fin = 1'b1; code_nx = RC_BYTE;
        end else if (!hit) begin
          fin = 1'b1; code_nx = RC_ADDR;
        end else begin
          st_nx = ST_LEN;
        end
      end
      ST_LEN: if (hs) begin
        if (in_bad) begin
          fin = 1'b1; code_nx = RC_BYTE;
        end else if (too_long) begin
          fin = 1'b1; code_nx = RC_SIZE;
        end else begin
          st_nx = ST_BODY;
        end
      end
      ST_BODY: if (hs) begin
        if (in_bad) begin
          fin = 1'b1; code_nx = RC_BYTE;
        end else if (last) begin
          fin = 1'b1;
        end
      end
      ST_RESULT: st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
    if (fin) st_nx = ST_RESULT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      own_q  <= '0;
      max_q  <= '0;
      ok_q   <= 1'b0;
      code_q <= RC_NONE;
    end else begin
      st <= st_nx;
      if (arm) begin
        own_q <= own_addr;
        max_q <= max_len;
      end
      if (fin) begin
        ok_q   <= (code_nx == RC_NONE);
        code_q <= code_nx;
      end
    end
  end

  assign wr_addr  = ptr;
  assign wr_data  = in_data;
  assign done     = (st == ST_RESULT);
  assign ok       = done & ok_q;
  assign err_code = done ? code_q : 2'd0;
endmodule

// File: rtl/pktrx_chk.sv
module pktrx_chk #(
  parameter int W          = 8,
  parameter bit ACCEPT_ALL = 1'b0,
  localparam int PW        = W + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  own_addr,
  input logic [W-1:0]  max_len,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_bad,
  input logic          wr_en,
  input logic [PW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic          done,
  input logic          ok,
  input logic [1:0]    err_code
);
  logic [PW-1:0] exp_ptr;
  logic [W-1:0]  len_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_ptr  <= '0;
      len_seen <= '0;
    end else begin
      if (done)
        exp_ptr <= '0;
      else if (wr_en)
        exp_ptr <= exp_ptr + PW'(1);
      if (wr_en && wr_addr == PW'(1))
        len_seen <= wr_data;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !wr_en));
  assert_ok_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok == (err_code == 2'd0)));
  assert_idle_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!ok && err_code == 2'd0));
  assert_wr_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (in_valid && in_ready && !in_bad));
  assert_wr_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == exp_ptr));
  assert_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && !ACCEPT_ALL) |->
      (wr_data == own_addr || wr_data == {W{1'b1}}));
  assert_oversize_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |->
      ($past(wr_en) && $past(wr_addr) == PW'(1) && $past(wr_data) >= max_len));
  assert_full_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |->
      ($past(wr_en) && $past(wr_addr) == ({1'b0, len_seen} + PW'(2))));
  assert_byte_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd3) |->
      $past(in_valid && in_ready && in_bad));
endmodule

bind addr_pkt_rx pktrx_chk #(.W(W), .ACCEPT_ALL(ACCEPT_ALL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .own_addr (own_addr),
  .max_len  (max_len),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_bad   (in_bad),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .done     (done),
  .ok       (ok),
  .err_code (err_code)
);

// File: tb/sim_addr_pkt_rx.sv
`timescale 1ns/1ps
module sim_addr_pkt_rx;
  localparam int W  = 8;
  localparam int PW = W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic sel = 1'b0;
  logic start = 1'b0, valid = 1'b0, bad = 1'b0;
  logic [W-1:0] data = '0, own = 8'h35, maxl = 8'd6;

  logic rdy0, rdy1, we0, we1, dn0, dn1, ok0, ok1;
  logic [PW-1:0] wa0, wa1;
  logic [W-1:0] wd0, wd1;
  logic [1:0] ec0, ec1;

  addr_pkt_rx #(.W(W), .ACCEPT_ALL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start & ~sel), .own_addr(own), .max_len(maxl),
    .in_valid(valid & ~sel), .in_ready(rdy0), .in_data(data), .in_bad(bad),
    .wr_en(we0), .wr_addr(wa0), .wr_data(wd0), .done(dn0), .ok(ok0), .err_code(ec0));

  addr_pkt_rx #(.W(W), .ACCEPT_ALL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start & sel), .own_addr(own), .max_len(maxl),
    .in_valid(valid & sel), .in_ready(rdy1), .in_data(data), .in_bad(bad),
    .wr_en(we1), .wr_addr(wa1), .wr_data(wd1), .done(dn1), .ok(ok1), .err_code(ec1));

  logic rdy, we, dn, okm;
  logic [PW-1:0] wa;
  logic [W-1:0] wd;
  logic [1:0] ecm;
  assign rdy = sel ? rdy1 : rdy0;
  assign we  = sel ? we1  : we0;
  assign wa  = sel ? wa1  : wa0;
  assign wd  = sel ? wd1  : wd0;
  assign dn  = sel ? dn1  : dn0;
  assign okm = sel ? ok1  : ok0;
  assign ecm = sel ? ec1  : ec0;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] pk  [0:299];
  logic [7:0] cap [0:511];
  int wcount, done_cycles, r_code;
  bit got_done, r_ok, mid_start;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (dn) begin
      got_done = 1'b1;
      r_ok = okm;
      r_code = int'(ecm);
      done_cycles++;
    end
  end

  task automatic run_pkt(input int n, input int bad_at, input int gap);
    got_done = 1'b0; wcount = 0; done_cycles = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n && !got_done; i++) begin
      for (int g = 0; g < gap; g++) @(negedge clk);
      valid = 1'b1; data = pk[i]; bad = (i == bad_at);
      if (mid_start && i == 3) start = 1'b1;
      forever begin
        #2;
        if (got_done) break;
        if (rdy) begin
          if (we) begin
            chk("R9", "wr_addr", int'(wa), wcount);
            cap[wcount] = wd;
            wcount++;
          end
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      start = 1'b0; valid = 1'b0; bad = 1'b0;
    end
    for (int t = 0; t < 50 && !got_done; t++) begin
      @(negedge clk); #2;
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic build(input logic [7:0] dest, input int len, input int seed);
    pk[0] = dest;
    pk[1] = 8'(len);
    for (int k = 0; k <= len && k < 297; k++) pk[2 + k] = 8'((k * 37 + seed) & 255);
  endtask

  task automatic one(input string req, input logic [7:0] dest, input int len,
                     input int bad_at, input int gap, input bit acc_all);
    int exp_code, exp_w;
    bit acc;
    build(dest, len, int'(dest) + len);
    run_pkt(len + 3, bad_at, gap);
    acc = acc_all || dest == own || dest == 8'hFF;
    if (bad_at == 0) begin exp_code = 3; exp_w = 0; end
    else if (!acc) begin exp_code = 1; exp_w = 0; end
    else if (bad_at == 1) begin exp_code = 3; exp_w = 1; end
    else if (len >= int'(maxl)) begin exp_code = 2; exp_w = 2; end
    else if (bad_at >= 2 && bad_at <= len + 2) begin exp_code = 3; exp_w = bad_at; end
    else begin exp_code = 0; exp_w = len + 3; end
    chk(req, "done seen", int'(got_done), 1);
    chk("R8", "done cycles", done_cycles, 1);
    chk(req, "err_code", r_code, exp_code);
    chk("R8", "ok", int'(r_ok), int'(exp_code == 0));
    chk(req, "write count", wcount, exp_w);
    for (int k = 0; k < exp_w && k < wcount; k++)
      chk(req, "buffer byte", int'(cap[k]), int'(pk[k]));
    chk("R2", "ready after result", int'(rdy), 0);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mid_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", int'(rdy0), 0);
    chk("R1", "wr_en in reset", int'(we0), 0);
    chk("R1", "done in reset", int'(dn0), 0);
    chk("R1", "err_code in reset", int'(ec0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", int'(dn0), 0);
    chk("R1", "ok after reset", int'(ok0), 0);

    // R2: offered bytes without start are never taken
    valid = 1'b1; data = 8'h35;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); #2;
      chk("R2", "ready without start", int'(rdy0), 0);
      chk("R2", "write without start", int'(we0), 0);
    end
    valid = 1'b0;

    // R3: every destination value, own address 0x35
    for (int d = 0; d < 256; d++) one("R3", 8'(d), 1, -1, d % 3, 1'b0);
    own = 8'hA0;
    one("R3", 8'hA0, 2, -1, 0, 1'b0);
    one("R3", 8'h35, 2, -1, 0, 1'b0);
    one("R3", 8'hFF, 0, -1, 1, 1'b0);

    // R5 and R6: lengths on both sides of several ceilings
    foreach (pk[i]) if (i < 0) pk[i] = 0;
    for (int m = 0; m < 4; m++) begin
      maxl = (m == 0) ? 8'd0 : (m == 1) ? 8'd1 : (m == 2) ? 8'd6 : 8'd9;
      for (int l = 0; l < 12; l++)
        one((l >= int'(maxl)) ? "R5" : "R6", 8'hA0, l, -1, l % 2, 1'b0);
    end
    maxl = 8'd255;
    one("R6", 8'hFF, 254, -1, 0, 1'b0);
    one("R5", 8'hFF, 255, -1, 0, 1'b0);

    // R7: receive error at every position
    maxl = 8'd6;
    for (int b = 0; b < 8; b++) one("R7", 8'hA0, 4, b, b % 2, 1'b0);
    one("R7", 8'h11, 4, 1, 0, 1'b0);

    // R2: start pulse during a packet is ignored
    mid_start = 1'b1;
    one("R2", 8'hA0, 5, -1, 0, 1'b0);
    mid_start = 1'b0;
    repeat (3) begin
      @(negedge clk); #2;
      chk("R2", "idle after ignored start", int'(rdy0), 0);
    end

    // R4: accept-all instance
    sel = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 256; d += 5) one("R4", 8'(d), 3, -1, 0, 1'b1);
    one("R4", 8'h35, 7, -1, 0, 1'b1);
    one("R4", 8'h02, 3, 3, 0, 1'b1);
    sel = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule